// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two N-bit two's-complement numbers over N clock cycles using one narrow adder/subtractor. A one-cycle `start` while the block is idle captures the multiplicand, clears the upper half of a 2N-bit product register and loads the multiplier into the lower half. Each following cycle the least significant bit of the product register selects whether the multiplicand is combined into the upper half. The register then shifts right by one place, so a fresh multiplier bit reaches the bottom on every step.

On the first N-1 steps the gated multiplicand is added. On the last step it is subtracted, because the multiplier's top bit carries weight -2^(N-1). No pre-negation or post-negation of either operand is needed. The adder works on N+1 bits, and its top bit is the sign that enters the product register as it shifts. When the run ends, `done` pulses for one cycle and the product stays valid until the next accepted start.

Top module: `smul_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `product` are all zero until the first start is accepted.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high in the following cycle and stays high for exactly N cycles.
- R3: `done` is high for exactly one cycle, N cycles after the accepting edge. `busy` is low in that cycle.
- R4: For a non-negative multiplicand and a non-negative multiplier, `product` equals their 2N-bit two's-complement product in the `done` cycle.
- R5: A negative multiplicand with a non-negative multiplier gives the correct signed product, because partial sums are sign-extended.
- R6: A negative multiplier (top bit 1) gives the correct signed product, because the last step subtracts the gated multiplicand.
- R7: The most negative multiplicand times the most negative multiplier gives +2^(2N-2).
- R8: A `start` sampled while `busy` is high is ignored. The running product, its operands and the `done` timing are unchanged.
- R9: After `done`, `product` holds its value while no start is accepted, even if the operand inputs change.
- R10: Operands are captured at the accepting edge. Later changes on the operand inputs during the run do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| start | input | 1 | Begin a multiplication when idle |
| mcand_i | input | N | Multiplicand, two's complement |
| mplier_i | input | N | Multiplier, two's complement |
| busy | output | 1 | High while the shift-add steps run |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2N | Signed product, held until the next accepted start |

## Verification
The bench builds the block with N = 4. This makes an exhaustive sweep of all 256 operand pairs cheap. Every sign combination, zero, -1 and the -8 x -8 = +64 extreme are checked arithmetically against the bench's own integer product. At this width the sweep also reaches cycle-exact busy and done timing, start pulses injected mid-run, operand changes after capture, and product hold after completion.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smul_state_e;
endpackage

// File: rtl/smul_rst_sync.sv
module smul_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/smul_step_ctr.sv
module smul_step_ctr #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | en;
    cnt_d  = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last,
  output logic load,
  output logic step,
  output logic sub_sel,
  output logic busy,
  output logic done
);
  smul_state_e state_q;
  smul_state_e state_d;
  logic        done_q;
  logic        done_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    sub_sel = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step    = 1'b1;
        sub_sel = last;
        if (last) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;
endmodule

// File: rtl/smul_addsub.sv
module smul_addsub #(
  parameter int N = 8
) (
  input  logic [N-1:0] acc_hi,
  input  logic [N-1:0] mcand,
  input  logic         bit_en,
  input  logic         sub_sel,
  output logic [N:0]   result
);
  logic [N-1:0] gated;
  logic [N:0]   ext_acc;
  logic [N:0]   ext_pp;

  for (genvar g = 0; g < N; g++) begin : g_and
    assign gated[g] = mcand[g] & bit_en;
  end

  always_comb begin
    ext_acc = {acc_hi[N-1], acc_hi};
    ext_pp  = {gated[N-1], gated};
    if (sub_sel) result = ext_acc - ext_pp;
    else         result = ext_acc + ext_pp;
  end
endmodule

// File: rtl/smul_seq.sv
module smul_seq #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int PW = 2 * N;

  logic          rst_sync_n;
  logic          load;
  logic          step;
  logic          sub_sel;
  logic          last;
  logic [N-1:0]  mcand_q;
  logic [PW-1:0] prod_q;
  logic [PW-1:0] prod_d;
  logic          prod_en;
  logic [N:0]    sum;

  smul_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  smul_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .last    (last),
    .load    (load),
    .step    (step),
    .sub_sel (sub_sel),
    .busy    (busy),
    .done    (done)
  );

  smul_step_ctr #(.N(N)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (load),
    .en    (step),
    .last  (last)
  );

  smul_addsub #(.N(N)) u_addsub (
    .acc_hi  (prod_q[PW-1:N]),
    .mcand   (mcand_q),
    .bit_en  (prod_q[0]),
    .sub_sel (sub_sel),
    .result  (sum)
  );

  always_comb begin
    prod_en = load | step;
    prod_d  = prod_q;
    if (load)      prod_d = {{N{1'b0}}, mplier_i};
    else if (step) prod_d = {sum, prod_q[N-1:1]};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mcand_q <= '0;
    else if (load)   mcand_q <= mcand_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  prod_q <= '0;
    else if (prod_en) prod_q <= prod_d;
  end

  assign product = prod_q;
endmodule

// File: rtl/smul_seq_chk.sv
module smul_seq_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);
  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == N));

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

bind smul_seq smul_seq_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/smul_seq_bench.sv
module smul_seq_bench;
  localparam int N  = 4;
  localparam int PW = 2 * N;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [N-1:0]  mcand_i;
  logic [N-1:0]  mplier_i;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  int checks;
  int failures;
  bit finished;

  smul_seq #(.N(N)) u_smul_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .busy     (busy),
    .done     (done),
    .product  (product)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [PW-1:0] ref_prod(input logic [N-1:0] a, input logic [N-1:0] b);
    int ia;
    int ib;
    int p;
    ia = $signed(a);
    ib = $signed(b);
    p  = ia * ib;
    return p[PW-1:0];
  endfunction

  task automatic run_pair(input logic [N-1:0] a, input logic [N-1:0] b,
                          input bit intrude, input bit full);
    logic [PW-1:0] exp;
    logic [PW-1:0] held;
    string tag;
    exp = ref_prod(a, b);
    if (a == {1'b1, {(N-1){1'b0}}} && b == {1'b1, {(N-1){1'b0}}}) tag = "R7";
    else if (b[N-1]) tag = "R6";
    else if (a[N-1]) tag = "R5";
    else             tag = "R4";
    @(negedge clk);
    start    = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    @(negedge clk);
    start    = 1'b0;
    mcand_i  = ~a;
    mplier_i = ~b;
    if (full) begin
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      chk(done == 1'b0, "R3 done early", done, 0);
    end
    for (int i = 1; i < N; i++) begin
      start = intrude && (i == 1);
      if (intrude && i == 1) begin
        mcand_i  = a + 1'b1;
        mplier_i = b ^ 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (full) begin
        chk(busy == 1'b1, intrude ? "R8 busy kept" : "R2 busy held", busy, 1);
        chk(done == 1'b0, "R3 done early", done, 0);
      end
    end
    @(negedge clk);
    chk(done == 1'b1, intrude ? "R8 done timing" : "R3 done pulse", done, 1);
    chk(busy == 1'b0, "R3 busy low at done", busy, 0);
    chk(product == exp, intrude ? "R8 product" : tag, $signed(product), $signed(exp));
    if (full) begin
      held = product;
      mcand_i  = a ^ 4'h5;
      mplier_i = b ^ 4'hA;
      @(negedge clk);
      chk(done == 1'b0, "R3 done one cycle", done, 0);
      @(negedge clk);
      chk(product == held, "R9 product hold", product, held);
      chk(busy == 1'b0, "R9 stays idle", busy, 0);
    end
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    finished = 1'b0;
    start    = 1'b0;
    mcand_i  = '0;
    mplier_i = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(product == '0, "R1 product in reset", product, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(product == '0, "R1 product after reset", product, 0);

    // R10: operands change right after capture inside run_pair
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        run_pair(N'(a), N'(b), 1'b0, (b % 5) == 0);
      end
    end

    // R7 explicit extreme with full timing
    run_pair({1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}}, 1'b0, 1'b1);
    chk(product == PW'(1 << (PW - 2)), "R7 extreme", product, 1 << (PW - 2));

    // R8 start pulses while busy
    run_pair(4'h3, 4'hB, 1'b1, 1'b1);
    run_pair(4'h9, 4'h7, 1'b1, 1'b1);
    run_pair(4'hF, 4'h8, 1'b1, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule